// File: doc/BRIEF.md
# State Save Engine

The state save engine copies the internal state of a halted core into memory. Once the core has stopped at a safe point, a controller can ask how many words of state the core holds. It then issues a save command that carries the destination memory address. The engine walks the core's state one word per cycle through an index-and-data read port and gathers the words in a 32-bit FIFO.

Each time the FIFO is full, its whole contents go out as one block write. If fewer words are left than the FIFO can hold, they go out as one final sequence write of the matching length. The writes land back to back in memory. A one-cycle done pulse reports that the last word has been accepted.

The memory side is a plain request/acknowledge port. Each write presents its start address, its length, its kind and a stream of data beats. The port holds every value until the beat is acknowledged.

Top module: `state_save_engine`

## Requirements
- R1: A size query (`size_req` high for one cycle) is answered on the next cycle with `size_valid` high for one cycle and `size_words` equal to `core_len`.
- R2: A save command (`save_req` while `busy` is low) captures `save_addr` and `core_len`, and raises `busy` on the next cycle. `busy` stays high until the done pulse has ended.
- R3: State is read with `st_rd` high and `st_idx` counting 0, 1, … L-1 in order, one word per cycle. `st_data` is taken in the same cycle as its index, and `st_rd` never overlaps `mem_req`.
- R4: Each time DEPTH words have been gathered, they are issued as one block write, marked by `mem_blk` = 1 and `mem_len` = DEPTH.
- R5: A remainder of L mod DEPTH words (when non-zero) is issued as one sequence write, marked by `mem_blk` = 0 and `mem_len` = L mod DEPTH.
- R6: The first write starts at the captured address. Each later write starts at the previous start address plus the previous length, so word i lands at base + i.
- R7: During a write, `mem_req`, `mem_addr`, `mem_len`, `mem_blk` and `mem_wdata` hold steady until `mem_ack` is seen. Beat k carries the k-th word of that write, and `mem_last` marks the final beat.
- R8: `done` is a one-cycle pulse in the cycle after the final beat is acknowledged.
- R9: A save with `core_len` = 0 gives `done` in the cycle after the command, with no memory write and no state read.
- R10: State lengths of 1 word, fewer than DEPTH words, exactly DEPTH words and more than DEPTH words are all stored completely and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| size_req | input | 1 | Size query strobe |
| size_valid | output | 1 | Size answer strobe |
| size_words | output | LEN_W | State length in words |
| core_len | input | LEN_W | State length reported by the core |
| save_req | input | 1 | Save command strobe |
| save_addr | input | ADDR_W | Destination word address |
| busy | output | 1 | Save in progress |
| done | output | 1 | Save complete pulse |
| st_rd | output | 1 | State read enable |
| st_idx | output | LEN_W | State word index |
| st_data | input | DATA_W | State word at `st_idx` |
| mem_req | output | 1 | Write beat request |
| mem_ack | input | 1 | Beat accepted |
| mem_addr | output | ADDR_W | Start address of current write |
| mem_len | output | CNT_W | Words in current write |
| mem_blk | output | 1 | 1 = block write, 0 = sequence write |
| mem_wdata | output | DATA_W | Current beat data |
| mem_last | output | 1 | Final beat of current write |

## Verification
The size answer is due exactly one cycle after the query. A zero-length save's done pulse is due exactly one cycle after the command. The checks for both sample at the falling edge that follows one rising edge. Longer saves have a variable latency set by the acknowledge pattern, so the bench waits for the done pulse and checks that it lasts one cycle and that `busy` drops at that point. It then compares the recorded writes (kind, length, start address) and the stored words against values computed from L and DEPTH. Beats are recorded only at rising edges where request and acknowledge are both high, and acknowledge is changed only at falling edges, so stalls are seen the same way the design sees them.

// File: rtl/state_save_engine.sv
module state_save_engine #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              size_req,
  output logic              size_valid,
  output logic [LEN_W-1:0]  size_words,
  input  logic [LEN_W-1:0]  core_len,
  input  logic              save_req,
  input  logic [ADDR_W-1:0] save_addr,
  output logic              busy,
  output logic              done,
  output logic              st_rd,
  output logic [LEN_W-1:0]  st_idx,
  input  logic [DATA_W-1:0] st_data,
  output logic              mem_req,
  input  logic              mem_ack,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CNT_W-1:0]  mem_len,
  output logic              mem_blk,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_last
);
  typedef enum logic [1:0] {S_IDLE, S_FILL, S_DRAIN, S_DONE} state_t;

  state_t              state;
  logic [DATA_W-1:0]   fifo [DEPTH];
  logic [CNT_W-1:0]    fill_cnt;
  logic [CNT_W-1:0]    rd_ptr;
  logic [LEN_W-1:0]    idx;
  logic [LEN_W-1:0]    len;
  logic [ADDR_W-1:0]   addr;

  wire fill_last  = (fill_cnt == CNT_W'(DEPTH - 1)) || (idx == len - LEN_W'(1));
  wire beat_last  = (rd_ptr == fill_cnt - CNT_W'(1));
  wire beat_go    = (state == S_DRAIN) && mem_ack;

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
  assign st_rd     = (state == S_FILL);
  assign st_idx    = idx;
  assign mem_req   = (state == S_DRAIN);
  assign mem_addr  = addr;
  assign mem_len   = fill_cnt;
  assign mem_blk   = (fill_cnt == CNT_W'(DEPTH));
  assign mem_wdata = fifo[rd_ptr[$clog2(DEPTH)-1:0]];
  assign mem_last  = mem_req && beat_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_valid <= 1'b0;
      size_words <= '0;
    end else begin
      size_valid <= size_req;
      if (size_req) size_words <= core_len;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      fill_cnt <= '0;
      rd_ptr   <= '0;
      idx      <= '0;
      len      <= '0;
      addr     <= '0;
    end else begin
      case (state)
        S_IDLE: if (save_req) begin
          len      <= core_len;
          addr     <= save_addr;
          idx      <= '0;
          fill_cnt <= '0;
          state    <= (core_len == '0) ? S_DONE : S_FILL;
        end
        S_FILL: begin
          fifo[fill_cnt[$clog2(DEPTH)-1:0]] <= st_data;
          fill_cnt <= fill_cnt + CNT_W'(1);
          idx      <= idx + LEN_W'(1);
          rd_ptr   <= '0;
          if (fill_last) state <= S_DRAIN;
        end
        S_DRAIN: if (beat_go) begin
          rd_ptr <= rd_ptr + CNT_W'(1);
          if (beat_last) begin
            addr     <= addr + ADDR_W'(fill_cnt);
            fill_cnt <= '0;
            state    <= (idx == len) ? S_DONE : S_FILL;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/state_save_engine_chk.sv
module state_save_engine_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              size_req,
  input logic              size_valid,
  input logic [LEN_W-1:0]  size_words,
  input logic [LEN_W-1:0]  core_len,
  input logic              save_req,
  input logic              busy,
  input logic              done,
  input logic              st_rd,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [CNT_W-1:0]  mem_len,
  input logic              mem_blk,
  input logic [DATA_W-1:0] mem_wdata
);
  assert_size_reply_R1: assert property (@(posedge clk) disable iff (!rst_n)
    size_req |=> size_valid && size_words == $past(core_len));

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !busy) |=> busy);

  assert_no_read_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_rd && mem_req));

  assert_block_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_blk) |-> mem_len == CNT_W'(DEPTH));

  assert_seq_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_blk) |-> (mem_len != '0) && (mem_len < CNT_W'(DEPTH)));

  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_len)
                              && $stable(mem_blk) && $stable(mem_wdata));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !busy && core_len == '0) |=> done && !mem_req && !st_rd);
endmodule

bind state_save_engine state_save_engine_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .size_req(size_req), .size_valid(size_valid),
  .size_words(size_words), .core_len(core_len), .save_req(save_req),
  .busy(busy), .done(done), .st_rd(st_rd), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_len(mem_len), .mem_blk(mem_blk), .mem_wdata(mem_wdata)
);

// File: tb/state_save_engine_tb_top.sv
module state_save_engine_tb_top;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int DEPTH  = 8;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              size_req = 1'b0, save_req = 1'b0, mem_ack = 1'b0;
  logic [LEN_W-1:0]  core_len = '0;
  logic [ADDR_W-1:0] save_addr = '0;
  logic              size_valid, busy, done, st_rd, mem_req, mem_blk, mem_last;
  logic [LEN_W-1:0]  size_words, st_idx;
  logic [DATA_W-1:0] st_data, mem_wdata;
  logic [ADDR_W-1:0] mem_addr;
  logic [CNT_W-1:0]  mem_len;
  logic [15:0]       tag = 16'h0;

  assign st_data = {tag, st_idx};

  state_save_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .size_req(size_req), .size_valid(size_valid),
    .size_words(size_words), .core_len(core_len), .save_req(save_req),
    .save_addr(save_addr), .busy(busy), .done(done), .st_rd(st_rd), .st_idx(st_idx),
    .st_data(st_data), .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .mem_len(mem_len), .mem_blk(mem_blk), .mem_wdata(mem_wdata), .mem_last(mem_last)
  );

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [ADDR_W-1:0] base = '0;
  logic [DATA_W-1:0] store [64];
  bit                wrote [64];
  int                wr_cnt = 0, beat = 0, beats = 0, last_err = 0;
  logic [ADDR_W-1:0] wr_addr [16];
  int                wr_len [16];
  bit                wr_blk [16];
  int                cyc = 0;
  bit                stall = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_ack) begin
      int off;
      off = int'(mem_addr - base) + beat;
      if (beat == 0 && wr_cnt < 16) begin
        wr_addr[wr_cnt] = mem_addr;
        wr_len[wr_cnt]  = int'(mem_len);
        wr_blk[wr_cnt]  = mem_blk;
      end
      if (off >= 0 && off < 64) begin
        store[off] = mem_wdata;
        wrote[off] = 1'b1;
      end
      beats++;
      if (mem_last != (beat == int'(mem_len) - 1)) last_err++;
      if (mem_last) begin
        beat = 0;
        wr_cnt++;
      end else beat++;
    end
  end

  always @(negedge clk) mem_ack <= stall ? ((cyc % 3) != 0) : 1'b1;

  task automatic run_save(input int L, input logic [ADDR_W-1:0] b, input bit st);
    int n_blk, rem, exp_w, wait_c;
    stall = st;
    base = b;
    tag = tag + 16'h1;
    for (int i = 0; i < 64; i++) wrote[i] = 1'b0;
    wr_cnt = 0; beat = 0; beats = 0; last_err = 0;
    @(negedge clk);
    core_len = LEN_W'(L); save_addr = b; save_req = 1'b1;
    @(negedge clk);
    save_req = 1'b0;
    if (L == 0) begin
      chk(done == 1'b1, "R9 done one cycle after zero save", done, 1);
      @(negedge clk);
      chk(wr_cnt == 0, "R9 no write for zero size", wr_cnt, 0);
      chk(busy == 1'b0, "R9 idle after zero save", busy, 0);
      return;
    end
    chk(busy == 1'b1, "R2 busy after save", busy, 1);
    wait_c = 0;
    while (!done && wait_c < 2000) begin
      @(negedge clk);
      wait_c++;
    end
    chk(done == 1'b1, "R8 done seen", done, 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R8 done lasts one cycle, busy drops", {done, busy}, 0);
    n_blk = L / DEPTH;
    rem   = L % DEPTH;
    exp_w = n_blk + (rem != 0 ? 1 : 0);
    chk(wr_cnt == exp_w, "R10 write count", wr_cnt, exp_w);
    chk(beats == L, "R10 total beats", beats, L);
    chk(last_err == 0, "R7 last beat marking", last_err, 0);
    for (int w = 0; w < exp_w && w < wr_cnt; w++) begin
      bit eb; int el;
      eb = (w < n_blk);
      el = eb ? DEPTH : rem;
      if (eb) chk(wr_blk[w] == 1'b1 && wr_len[w] == DEPTH, "R4 block write", wr_len[w], DEPTH);
      else    chk(wr_blk[w] == 1'b0 && wr_len[w] == el, "R5 sequence write", wr_len[w], el);
      chk(wr_addr[w] == b + ADDR_W'(w * DEPTH), "R6 write start address", wr_addr[w], b + ADDR_W'(w * DEPTH));
    end
    for (int i = 0; i < L; i++)
      chk(wrote[i] && store[i] == {tag, 16'(i)}, "R3 R10 stored word", store[i], {tag, 16'(i)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req && !size_valid && !st_rd, "reset state",
        {busy, done, mem_req, size_valid, st_rd}, 0);

    for (int L = 0; L < 20; L += 3) begin
      @(negedge clk);
      core_len = LEN_W'(L); size_req = 1'b1;
      @(negedge clk);
      size_req = 1'b0;
      chk(size_valid && size_words == LEN_W'(L), "R1 size answer", size_words, L);
      @(negedge clk);
      chk(!size_valid, "R1 size strobe one cycle", size_valid, 0);
    end

    for (int L = 0; L <= 2 * DEPTH + 3; L++) begin
      run_save(L, ADDR_W'(32'h1000 + L * 64), 1'b0);
      run_save(L, ADDR_W'(32'h8000 + L * 3), 1'b1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule